// File: doc/BRIEF.md
# Periodic Wake Timer with Pre-Kick

This block produces a periodic kick pulse for a sensor-processing engine. Ahead of each kick it raises a wake request toward the power manager, so the engine's power domain is already up when the kick arrives. Time is counted in ticks: single-cycle enables in the system clock domain that come from one of two slow rates. A configuration bit selects which rate is used. A free-running 30-bit timestamp counts every selected tick, whatever the timer's own state.

Software writes one 32-bit configuration word and can read it back. The word holds the run enable, the tick-rate select, eight mask bits for eight interrupt triggers, the kick period in ticks, and the wake lead time in ticks. A zero lead changes the handshake: the timeout raises the wake request, and the kick waits until the engine reports that it is alive. A zero period, or a cleared enable, silences the timer. Only the timestamp keeps running.

Top module: `wake_kick_timer`

## Requirements
- R1: Configuration word layout: bit 0 run enable, bit 1 tick select, bits 2..9 trigger masks (bit 2+i masks trigger i), bits 10..17 period, bits 18..21 lead. After reset every field reads 0. A write stores bits 21..0 unchanged, and readback returns them with bits 31..22 as 0.
- R2: Tick select 0 counts only `tick_fast` (32 kHz source). Tick select 1 counts only `tick_slow` (16 kHz source). A pulse on the unselected input has no effect.
- R3: `stamp` increments by one on every selected tick, whatever the enable, period or lead settings, and holds otherwise.
- R4: While the enable is 0 or the period is 0, `kick` and `wake_req` stay low and the event counter is held at zero.
- R5: Counting starts from zero at a restart. `kick` is a one-cycle pulse in the cycle after every P-th selected tick, where P is the effective period. This holds when the lead is nonzero, or when the lead is zero and `eng_alive` is high.
- R6: A programmed period above 100 behaves as a period of 100.
- R7: With a lead N where 1 <= N < P, `wake_req` rises in the cycle after tick P-N of each period. It stays high through tick P-1 and is low in the kick cycle.
- R8: With a lead N >= P, `wake_req` is high continuously while the timer runs, including the kick cycle.
- R9: With lead 0 and `eng_alive` low at the timeout, `wake_req` goes high and `kick` is withheld. In the cycle after `eng_alive` is first seen high, `kick` pulses once and `wake_req` drops.
- R10: A write that changes the enable, period or lead clears the event counter, and counting resumes with the next selected tick. A write that changes only the masks or the tick select leaves the count undisturbed.
- R11: `irq_out[i]` equals `irq_raw[i]` when mask bit 2+i is 0, and is 0 when that mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| tick_fast | input | 1 | Single-cycle tick enable from the 32 kHz source |
| tick_slow | input | 1 | Single-cycle tick enable from the 16 kHz source |
| eng_alive | input | 1 | Engine-alive handshake |
| irq_raw | input | 8 | Unmasked interrupt triggers |
| irq_out | output | 8 | Masked interrupt triggers |
| kick | output | 1 | One-cycle kick pulse to the engine |
| wake_req | output | 1 | Power-up request to the power manager |
| stamp | output | 30 | Free-running tick timestamp |

## Verification
A corrupted event count shows at the ports within one period: the next kick lands on the wrong tick, and the wake edge moves relative to it. The sweep over periods 1 to 6 and every lead up to P+1 therefore compares `kick` and `wake_req` after every single tick. A stuck handshake latch shows as a kick that fires with `eng_alive` low, or as one that never fires once it is high, in the first cycle after the alive edge. A timestamp fault appears at the very next selected tick, because `stamp` is compared against a running count after every pulse.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
    localparam int NIRQ     = 8;
    localparam int PER_W    = 8;
    localparam int LEAD_W   = 4;
    localparam int TS_W     = 30;
    localparam int PER_MAX  = 100;
    localparam int REG_W    = 32;
    localparam int CFG_USED = 2 + NIRQ + PER_W + LEAD_W;

    // field order matches the software-visible bit positions (en at bit 0)
    typedef struct packed {
        logic [LEAD_W-1:0] lead;
        logic [PER_W-1:0]  period;
        logic [NIRQ-1:0]   mask;
        logic              sel;
        logic              en;
    } cfg_t;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             pend;
        logic             kick;
        logic             wake;
    } core_st_t;
endpackage

// File: rtl/wkt_cfg_reg.sv
module wkt_cfg_reg
    import wkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg_q,
    output cfg_t             cfg_n,
    output logic             restart,
    output logic [REG_W-1:0] rdata
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d   = we ? cfg_t'(wdata[CFG_USED-1:0]) : cfg_q;
        cfg_n   = cfg_d;
        restart = we && ((cfg_d.en != cfg_q.en) ||
                         (cfg_d.period != cfg_q.period) ||
                         (cfg_d.lead != cfg_q.lead));
        rdata   = {{(REG_W-CFG_USED){1'b0}}, cfg_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata[CFG_USED-1:0] == $past(wdata[CFG_USED-1:0])); // R1
endmodule

// File: rtl/wkt_stamp.sv
module wkt_stamp
    import wkt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            tick_fast,
    input  logic            tick_slow,
    output logic            tick,
    output logic [TS_W-1:0] stamp_q
);
    logic [TS_W-1:0] stamp_d;

    always_comb begin
        tick    = sel ? tick_slow : tick_fast;
        stamp_d = tick ? stamp_q + TS_W'(1) : stamp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stamp_q <= '0;
        else        stamp_q <= stamp_d;
    end

    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> stamp_q == $past(stamp_q) + TS_W'(1)); // R3
    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_fast && !tick_slow) |=> $stable(stamp_q)); // R2
endmodule

// File: rtl/wkt_event_core.sv
module wkt_event_core
    import wkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PER_W-1:0]  period,
    input  logic [LEAD_W-1:0] lead,
    input  logic              restart,
    input  logic              tick,
    input  logic              alive,
    output logic              kick,
    output logic              wake
);
    localparam logic [PER_W-1:0] PER_CAP = PER_W'(PER_MAX);

    core_st_t         st_d, st_q;
    logic [PER_W-1:0] per_c, lead_e;
    logic             run, wrap, due;

    always_comb begin
        per_c  = (period > PER_CAP) ? PER_CAP : period;
        lead_e = PER_W'(lead);
        run    = en && (per_c != '0);
        st_d   = st_q;
        wrap   = 1'b0;

        if (!run || restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= per_c - PER_W'(1)) begin
                st_d.cnt = '0;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + PER_W'(1);
            end
        end

        if (lead_e == '0) begin
            due       = run && !restart && (st_q.pend || wrap);
            st_d.kick = due && alive;
            st_d.pend = due && !alive;
            st_d.wake = st_d.pend;
        end else begin
            due       = 1'b0;
            st_d.pend = 1'b0;
            st_d.kick = wrap;
            st_d.wake = run && ((lead_e >= per_c) || (st_d.cnt >= per_c - lead_e));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign kick = st_q.kick;
    assign wake = st_q.wake;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!kick && !wake)); // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> st_q.cnt < $past(per_c)); // R6
    AST_WAKE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && $past(lead) != '0) |-> $past(wake)); // R7
    AST_ALIVE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && $past(lead) == '0) |-> $past(alive)); // R9
endmodule

// File: rtl/wake_kick_timer.sv
module wake_kick_timer
    import wkt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                tick_fast,
    input  logic                tick_slow,
    input  logic                eng_alive,
    input  logic [NIRQ-1:0]     irq_raw,
    output logic [NIRQ-1:0]     irq_out,
    output logic                kick,
    output logic                wake_req,
    output logic [TS_W-1:0]     stamp
);
    cfg_t cfg_q, cfg_n;
    logic restart, tick;

    wkt_cfg_reg i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg_q(cfg_q), .cfg_n(cfg_n), .restart(restart), .rdata(cfg_rdata)
    );

    wkt_stamp i_stamp (
        .clk(clk), .rst_n(rst_n), .sel(cfg_q.sel),
        .tick_fast(tick_fast), .tick_slow(tick_slow),
        .tick(tick), .stamp_q(stamp)
    );

    wkt_event_core i_core (
        .clk(clk), .rst_n(rst_n), .en(cfg_n.en), .period(cfg_n.period),
        .lead(cfg_n.lead), .restart(restart), .tick(tick), .alive(eng_alive),
        .kick(kick), .wake(wake_req)
    );

    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
        assign irq_out[i] = irq_raw[i] & ~cfg_q.mask[i];
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & cfg_rdata[2 +: NIRQ]) == '0); // R11
endmodule

// File: tb/test_wake_kick_timer.sv
module test_wake_kick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick_fast = 1'b0, tick_slow = 1'b0, eng_alive = 1'b0;
    logic [7:0]  irq_raw = '0, irq_out;
    logic        kick, wake_req;
    logic [29:0] stamp;

    int n_vec = 0, n_bad = 0;
    logic        cur_sel = 1'b0;
    logic [29:0] ts_exp = '0;

    always #5 clk = ~clk;

    wake_kick_timer i_wake_kick_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .eng_alive(eng_alive), .irq_raw(irq_raw), .irq_out(irq_out),
        .kick(kick), .wake_req(wake_req), .stamp(stamp)
    );

    function automatic logic [31:0] mk(input logic en, input logic sel,
            input logic [7:0] msk, input logic [7:0] per, input logic [3:0] ld);
        return {10'b0, ld, per, msk, sel, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
        cur_sel = d[1];
    endtask

    task automatic pulse(input logic f, input logic s);
        @(negedge clk); tick_fast = f; tick_slow = s;
        @(negedge clk); tick_fast = 1'b0; tick_slow = 1'b0;
        if ((cur_sel && s) || (!cur_sel && f)) ts_exp++;
    endtask

    task automatic tk();
        pulse(!cur_sel, cur_sel);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic done();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        done();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R1 reset rdata", cfg_rdata, 32'h0);
        chk("R4 reset kick", {31'b0, kick}, 32'h0);
        chk("R4 reset wake", {31'b0, wake_req}, 32'h0);
        chk("R3 reset stamp", {2'b0, stamp}, 32'h0);
        // R1 readback
        wr(32'hFFFF_FFFF);
        chk("R1 readback ones", cfg_rdata, 32'h003F_FFFF);
        wr(32'hA512_3456);
        chk("R1 readback pattern", cfg_rdata, 32'h0012_3456);
        wr(32'h0);

        // R5 R7 R8 sweep, alive high
        eng_alive = 1'b1;
        for (int p = 1; p <= 6; p++) begin
            for (int n = 0; n <= p + 1; n++) begin
                wr(mk(1'b0, 1'b0, 8'h00, 8'(p), 4'(n)));
                wr(mk(1'b1, 1'b0, 8'h00, 8'(p), 4'(n)));
                chk("R8 wake at start", {31'b0, wake_req}, {31'b0, (n != 0 && n >= p)});
                for (int k = 1; k <= 2 * p + 1; k++) begin
                    int m;
                    logic ew;
                    tk();
                    m  = k % p;
                    ew = (n != 0) && ((n >= p) || (m >= p - n));
                    chk("R5 kick on tick", {31'b0, kick}, {31'b0, m == 0});
                    chk(n >= p ? "R8 wake" : (n == 0 ? "R9 wake" : "R7 wake"),
                        {31'b0, wake_req}, {31'b0, ew});
                    chk("R3 stamp", {2'b0, stamp}, {2'b0, ts_exp});
                    idle();
                    chk("R5 kick one cycle", {31'b0, kick}, 32'h0);
                end
            end
        end

        // R6 clamp: period 200 acts as 100
        wr(mk(1'b0, 1'b0, 8'h00, 8'd200, 4'd0));
        wr(mk(1'b1, 1'b0, 8'h00, 8'd200, 4'd0));
        for (int k = 1; k <= 101; k++) begin
            tk();
            if (k >= 99) chk("R6 clamp kick", {31'b0, kick}, {31'b0, k == 100});
        end

        // R9 zero lead, alive low
        eng_alive = 1'b0;
        wr(mk(1'b0, 1'b0, 8'h00, 8'd3, 4'd0));
        wr(mk(1'b1, 1'b0, 8'h00, 8'd3, 4'd0));
        tk(); tk();
        chk("R9 no wake before timeout", {31'b0, wake_req}, 32'h0);
        tk();
        chk("R9 wake at timeout", {31'b0, wake_req}, 32'h1);
        chk("R9 kick withheld", {31'b0, kick}, 32'h0);
        idle(); idle();
        chk("R9 still waiting", {30'b0, wake_req, kick}, 32'h2);
        eng_alive = 1'b1;
        idle();
        chk("R9 kick after alive", {30'b0, wake_req, kick}, 32'h1);
        idle();
        chk("R9 kick single", {30'b0, wake_req, kick}, 32'h0);

        // R10 restart on lead change
        wr(mk(1'b0, 1'b0, 8'h00, 8'd5, 4'd2));
        wr(mk(1'b1, 1'b0, 8'h00, 8'd5, 4'd2));
        tk(); tk(); tk();
        wr(mk(1'b1, 1'b0, 8'h00, 8'd5, 4'd1));
        for (int k = 1; k <= 5; k++) begin
            tk();
            chk("R10 restart kick", {31'b0, kick}, {31'b0, k == 5});
        end
        // R10 mask-only write keeps count
        wr(mk(1'b0, 1'b0, 8'h00, 8'd4, 4'd1));
        wr(mk(1'b1, 1'b0, 8'h00, 8'd4, 4'd1));
        tk(); tk();
        wr(mk(1'b1, 1'b0, 8'h5A, 8'd4, 4'd1));
        tk();
        chk("R10 mask write wake", {31'b0, wake_req}, 32'h1);
        tk();
        chk("R10 mask write kick", {31'b0, kick}, 32'h1);

        // R4 disabled and zero period
        wr(mk(1'b0, 1'b0, 8'h00, 8'd2, 4'd1));
        for (int k = 0; k < 4; k++) begin
            tk();
            chk("R4 disabled quiet", {30'b0, wake_req, kick}, 32'h0);
            chk("R3 stamp while disabled", {2'b0, stamp}, {2'b0, ts_exp});
        end
        wr(mk(1'b1, 1'b0, 8'h00, 8'd0, 4'd3));
        for (int k = 0; k < 4; k++) begin
            tk();
            chk("R4 zero period quiet", {30'b0, wake_req, kick}, 32'h0);
        end

        // R2 tick select
        wr(mk(1'b0, 1'b1, 8'h00, 8'd0, 4'd0));
        pulse(1'b1, 1'b0);
        chk("R2 fast ignored on slow select", {2'b0, stamp}, {2'b0, ts_exp});
        pulse(1'b0, 1'b1);
        chk("R2 slow counted", {2'b0, stamp}, {2'b0, ts_exp});
        wr(mk(1'b1, 1'b1, 8'h00, 8'd2, 4'd1));
        pulse(1'b1, 1'b0); pulse(1'b1, 1'b0);
        chk("R2 fast ignored by timer", {31'b0, kick}, 32'h0);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        chk("R2 slow drives kick", {31'b0, kick}, 32'h1);
        wr(mk(1'b0, 1'b0, 8'h00, 8'd0, 4'd0));
        pulse(1'b0, 1'b1);
        chk("R2 slow ignored on fast select", {2'b0, stamp}, {2'b0, ts_exp});

        // R11 exhaustive mask sweep
        for (int m = 0; m < 256; m++) begin
            wr(mk(1'b0, 1'b0, 8'(m), 8'd0, 4'd0));
            for (int r = 0; r < 4; r++) begin
                logic [7:0] raw;
                raw = (r == 0) ? 8'hFF : (r == 1) ? 8'h55 : (r == 2) ? 8'hAA : (8'(m) ^ 8'h3C);
                irq_raw = raw;
                #1;
                chk("R11 irq mask", {24'b0, irq_out}, {24'b0, raw & ~8'(m)});
            end
        end

        done();
    end
endmodule